// File: doc/BRIEF.md
# Programmable PLL Divider and Phase Detector Front-End

This block holds the digital dividers and the phase detector of a charge-pump PLL. The input clock is first divided by a prescaler that can be switched between 1 and 8. A programmable reference divider follows it. The oscillator clock is divided by a programmable feedback divider. A two-flop phase-frequency detector compares the two divided edges and drives `up` and `dn` correction requests. The analog charge pump, the loop filter and the oscillator are outside the block; the oscillator reaches it only as a clock.

Divide ratios come from static configuration pins that use offset codes. Each clock domain captures these pins once, on its first cycle after reset. A hold input, `hold_n`, supports a reference switch-over. While it is low, no correction requests are issued and the feedback divider is held. When it returns high, the feedback divider restarts from a known phase after the first input-clock edge. This removes the old phase from the feedback path, so the loop does not generate extra output cycles.

The divided reference and the divided feedback are exported as one-cycle ticks in their own clock domains. The divided reference is the loop's comparison-rate monitor.

Top module: `pll_div_front`

## Requirements
- R1: `ref_tick` repeats every P×(C+2) input-clock cycles, where C is `ref_code` (0 to 4095) and P is 1 when `pre_sel` is 0 and 8 when `pre_sel` is 1.
- R2: For `fb_code` values 0 to 4094, `fb_tick` repeats every `fb_code`+2 oscillator cycles.
- R3: When `fb_code` is all ones (4095), the feedback divide ratio is 1 and `fb_tick` is high on every oscillator cycle while the divider runs.
- R4: `ref_tick` is exactly one input-clock cycle wide. `fb_tick` is one oscillator cycle wide whenever the feedback ratio is not 1.
- R5: The configuration pins are captured on the first cycle after reset. Later changes to them have no effect on the tick periods until the next reset.
- R6: While `hold_n` is low (after its synchroniser), `up` and `dn` stay low and `fb_tick` stays low. `ref_tick` keeps running.
- R7: When `hold_n` returns high, the feedback divider stays held until the first input-clock edge is seen in the oscillator domain. Its first `fb_tick` then comes after one full feedback period, and correction requests resume.
- R8: A reference tick sets `up` and a feedback tick sets `dn`. When both are high in one oscillator cycle, both are low in the next cycle.
- R9: While `rst` is high, `up`, `dn`, `ref_tick` and `fb_tick` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock; feedback divider and phase detector domain |
| clk_ref | input | 1 | Input reference clock; prescaler and reference divider domain |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| hold_n | input | 1 | Low freezes correction and holds the feedback divider; high resumes with resync |
| pre_sel | input | 1 | Prescaler select: 0 gives divide by 1, 1 gives divide by 8 |
| ref_code | input | 12 | Reference divider code, ratio is code+2 |
| fb_code | input | 12 | Feedback divider code, ratio is code+2, all ones gives 1 |
| up | output | 1 | Phase detector request to speed the oscillator up |
| dn | output | 1 | Phase detector request to slow the oscillator down |
| ref_tick | output | 1 | Divided reference, one clk_ref cycle per period |
| fb_tick | output | 1 | Divided feedback, one clk_osc cycle per period |

## Verification
A divider counter loaded with the wrong offset, or a prescaler on the wrong branch, shows up one tick period after reset as a tick spacing that is off. A 4096-cycle feedback divider needs one full period to show a fault. A stuck freeze or run flag shows within a few cycles of a `hold_n` change. Either `up`/`dn` stay quiet after release, or `fb_tick` appears while the loop is held. If the phase detector fails to clear, both requests stay high for a second cycle. A wrong polarity shows as the wrong request dominating when one side runs much faster than the other.

// File: rtl/pll_div_pkg.sv
`timescale 1ns/1ps
package pll_div_pkg;
    localparam int CODE_W    = 12;
    localparam int CNT_W     = CODE_W + 1;
    localparam int PRE_RATIO = 8;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        cnt_t pre_m1;
        cnt_t ref_m1;
    } ref_cfg_t;

    typedef struct packed {
        logic unity;
        cnt_t fb_m1;
    } fb_cfg_t;

    function automatic ref_cfg_t decode_ref(input logic pre, input code_t code);
        ref_cfg_t r;
        r.pre_m1 = pre ? cnt_t'(PRE_RATIO - 1) : '0;
        r.ref_m1 = cnt_t'(code) + cnt_t'(1);
        return r;
    endfunction

    function automatic fb_cfg_t decode_fb(input code_t code);
        fb_cfg_t r;
        r.unity = &code;
        r.fb_m1 = r.unity ? '0 : cnt_t'(code) + cnt_t'(1);
        return r;
    endfunction
endpackage

// File: rtl/sync2.sv
`timescale 1ns/1ps
module sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tick_divider.sv
`timescale 1ns/1ps
module tick_divider #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         en,
    input  logic [W-1:0] m1,
    output logic         tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt  <= m1;
            tick <= 1'b0;
        end else if (en) begin
            if (cnt == '0) begin
                cnt  <= m1;
                tick <= 1'b1;
            end else begin
                cnt  <= cnt - 1'b1;
                tick <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/ref_path.sv
`timescale 1ns/1ps
module ref_path
    import pll_div_pkg::*;
(
    input  logic  clk_ref,
    input  logic  rst,
    input  logic  hold_n,
    input  logic  pre_sel,
    input  code_t ref_code,
    output logic  ref_tick,
    output logic  ref_tgl,
    output logic  start_tgl
);
    ref_cfg_t cfg;
    logic     cfg_ok;
    logic     pre_tick;
    logic     hold_s, hold_d;

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            cfg    <= '0;
            cfg_ok <= 1'b0;
        end else if (!cfg_ok) begin
            cfg    <= decode_ref(pre_sel, ref_code);
            cfg_ok <= 1'b1;
        end
    end

    tick_divider #(.W(CNT_W)) u_pre (
        .clk (clk_ref),
        .rst (rst),
        .hold(!cfg_ok),
        .en  (1'b1),
        .m1  (cfg.pre_m1),
        .tick(pre_tick)
    );

    tick_divider #(.W(CNT_W)) u_rdiv (
        .clk (clk_ref),
        .rst (rst),
        .hold(!cfg_ok),
        .en  (pre_tick),
        .m1  (cfg.ref_m1),
        .tick(ref_tick)
    );

    sync2 #(.RST_VAL(1'b0)) u_hold_sync (
        .clk(clk_ref),
        .rst(rst),
        .d  (hold_n),
        .q  (hold_s)
    );

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            hold_d    <= 1'b0;
            ref_tgl   <= 1'b0;
            start_tgl <= 1'b0;
        end else begin
            hold_d <= hold_s;
            if (ref_tick)
                ref_tgl <= !ref_tgl;
            if (hold_s && !hold_d)
                start_tgl <= !start_tgl;
        end
    end
endmodule

// File: rtl/fb_path.sv
`timescale 1ns/1ps
module fb_path
    import pll_div_pkg::*;
(
    input  logic  clk_osc,
    input  logic  rst,
    input  logic  hold_n,
    input  code_t fb_code,
    input  logic  ref_tgl,
    input  logic  start_tgl,
    output logic  fb_tick,
    output logic  ref_evt,
    output logic  fb_run,
    output logic  freeze,
    output logic  hold_s,
    output logic  unity
);
    fb_cfg_t cfg;
    logic    cfg_ok;
    logic    rt_s, rt_d;
    logic    st_s, st_d;
    logic    start_edge;

    always_ff @(posedge clk_osc) begin
        if (rst) begin
            cfg    <= '0;
            cfg_ok <= 1'b0;
        end else if (!cfg_ok) begin
            cfg    <= decode_fb(fb_code);
            cfg_ok <= 1'b1;
        end
    end

    sync2 #(.RST_VAL(1'b0)) u_hold_sync (
        .clk(clk_osc), .rst(rst), .d(hold_n), .q(hold_s)
    );
    sync2 #(.RST_VAL(1'b0)) u_ref_sync (
        .clk(clk_osc), .rst(rst), .d(ref_tgl), .q(rt_s)
    );
    sync2 #(.RST_VAL(1'b0)) u_start_sync (
        .clk(clk_osc), .rst(rst), .d(start_tgl), .q(st_s)
    );

    always_ff @(posedge clk_osc) begin
        if (rst) begin
            rt_d   <= 1'b0;
            st_d   <= 1'b0;
            fb_run <= 1'b0;
        end else begin
            rt_d <= rt_s;
            st_d <= st_s;
            if (!hold_s)
                fb_run <= 1'b0;
            else if (start_edge)
                fb_run <= 1'b1;
        end
    end

    assign ref_evt    = rt_s ^ rt_d;
    assign start_edge = st_s ^ st_d;
    assign freeze     = !fb_run || !hold_s;
    assign unity      = cfg.unity;

    tick_divider #(.W(CNT_W)) u_fdiv (
        .clk (clk_osc),
        .rst (rst),
        .hold(!fb_run || !cfg_ok),
        .en  (1'b1),
        .m1  (cfg.fb_m1),
        .tick(fb_tick)
    );
endmodule

// File: rtl/pfd2.sv
`timescale 1ns/1ps
module pfd2 (
    input  logic clk,
    input  logic rst,
    input  logic freeze,
    input  logic ref_evt,
    input  logic fb_evt,
    output logic up,
    output logic dn
);
    logic both;

    assign both = up && dn;

    always_ff @(posedge clk) begin
        if (rst || freeze || both) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up || ref_evt;
            dn <= dn || fb_evt;
        end
    end
endmodule

// File: rtl/pll_div_front.sv
`timescale 1ns/1ps
module pll_div_front
    import pll_div_pkg::*;
(
    input  logic              clk_osc,
    input  logic              clk_ref,
    input  logic              rst,
    input  logic              hold_n,
    input  logic              pre_sel,
    input  logic [CODE_W-1:0] ref_code,
    input  logic [CODE_W-1:0] fb_code,
    output logic              up,
    output logic              dn,
    output logic              ref_tick,
    output logic              fb_tick
);
    logic ref_tgl, start_tgl;
    logic ref_evt, fb_run, freeze, hold_osc, fb_unity;

    ref_path u_ref (
        .clk_ref  (clk_ref),
        .rst      (rst),
        .hold_n   (hold_n),
        .pre_sel  (pre_sel),
        .ref_code (ref_code),
        .ref_tick (ref_tick),
        .ref_tgl  (ref_tgl),
        .start_tgl(start_tgl)
    );

    fb_path u_fb (
        .clk_osc  (clk_osc),
        .rst      (rst),
        .hold_n   (hold_n),
        .fb_code  (fb_code),
        .ref_tgl  (ref_tgl),
        .start_tgl(start_tgl),
        .fb_tick  (fb_tick),
        .ref_evt  (ref_evt),
        .fb_run   (fb_run),
        .freeze   (freeze),
        .hold_s   (hold_osc),
        .unity    (fb_unity)
    );

    pfd2 u_pfd (
        .clk    (clk_osc),
        .rst    (rst),
        .freeze (freeze),
        .ref_evt(ref_evt),
        .fb_evt (fb_tick),
        .up     (up),
        .dn     (dn)
    );
endmodule

// File: rtl/pll_div_front_chk.sv
`timescale 1ns/1ps
module pll_div_front_chk (
    input logic clk_osc,
    input logic clk_ref,
    input logic rst,
    input logic up,
    input logic dn,
    input logic ref_tick,
    input logic fb_tick,
    input logic ref_evt,
    input logic fb_run,
    input logic hold_osc,
    input logic fb_unity
);
    assert_ref_narrow_R4: assert property (@(posedge clk_ref) disable iff (rst)
        ref_tick |=> !ref_tick);

    assert_fb_narrow_R4: assert property (@(posedge clk_osc) disable iff (rst)
        (fb_tick && !fb_unity) |=> !fb_tick);

    assert_hold_quiet_R6: assert property (@(posedge clk_osc) disable iff (rst)
        !hold_osc |=> (!up && !dn));

    assert_fb_needs_run_R7: assert property (@(posedge clk_osc) disable iff (rst)
        fb_tick |-> $past(fb_run));

    assert_pfd_clear_R8: assert property (@(posedge clk_osc) disable iff (rst)
        (up && dn) |=> (!up && !dn));

    assert_up_cause_R8: assert property (@(posedge clk_osc) disable iff (rst)
        $rose(up) |-> $past(ref_evt));
endmodule

bind pll_div_front pll_div_front_chk u_chk (
    .clk_osc (clk_osc),
    .clk_ref (clk_ref),
    .rst     (rst),
    .up      (up),
    .dn      (dn),
    .ref_tick(ref_tick),
    .fb_tick (fb_tick),
    .ref_evt (ref_evt),
    .fb_run  (fb_run),
    .hold_osc(hold_osc),
    .fb_unity(fb_unity)
);

// File: tb/test_pll_div_front.sv
`timescale 1ns/1ps
module test_pll_div_front;
    logic        clk_osc = 1'b0;
    logic        clk_ref = 1'b0;
    logic        rst = 1'b1;
    logic        hold_n = 1'b1;
    logic        pre_sel = 1'b0;
    logic [11:0] ref_code = '0;
    logic [11:0] fb_code = '0;
    logic        up, dn, ref_tick, fb_tick;

    int total = 0;
    int bad = 0;
    int ref_count = 0;

    always #2.5 clk_osc = !clk_osc;
    always #4.0 clk_ref = !clk_ref;

    pll_div_front i_pll_div_front (
        .clk_osc (clk_osc),
        .clk_ref (clk_ref),
        .rst     (rst),
        .hold_n  (hold_n),
        .pre_sel (pre_sel),
        .ref_code(ref_code),
        .fb_code (fb_code),
        .up      (up),
        .dn      (dn),
        .ref_tick(ref_tick),
        .fb_tick (fb_tick)
    );

    always @(negedge clk_ref) if (ref_tick) ref_count++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart(input logic pre, input logic [11:0] rc, input logic [11:0] fc);
        rst = 1'b1;
        hold_n = 1'b1;
        pre_sel = pre;
        ref_code = rc;
        fb_code = fc;
        repeat (20) @(negedge clk_osc);
        rst = 1'b0;
    endtask

    task automatic ref_period(output int n);
        int guard = 0;
        while (!ref_tick && guard < 70000) begin @(negedge clk_ref); guard++; end
        @(negedge clk_ref);
        n = 1;
        while (!ref_tick && n < 70000) begin @(negedge clk_ref); n++; end
    endtask

    task automatic fb_period(output int n);
        int guard = 0;
        while (!fb_tick && guard < 20000) begin @(negedge clk_osc); guard++; end
        @(negedge clk_osc);
        n = 1;
        while (!fb_tick && n < 20000) begin @(negedge clk_osc); n++; end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (20) @(negedge clk_osc);
        check(!up && !dn && !ref_tick && !fb_tick, "R9 outputs low in reset",
              {28'd0, up, dn, ref_tick, fb_tick}, 0);
        rst = 1'b0;
    endtask

    task automatic t_ref(input logic pre, input logic [11:0] rc);
        int n;
        int exp;
        restart(pre, rc, 12'd0);
        exp = (pre ? 8 : 1) * (int'(rc) + 2);
        ref_period(n);
        check(n == exp, "R1 reference tick period", n, exp);
    endtask

    task automatic t_ref_width;
        int hi = 0;
        restart(1'b0, 12'd0, 12'd0);
        repeat (4) @(negedge clk_ref);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_ref);
            if (ref_tick) hi++;
        end
        check(hi == 20, "R4 ref tick one cycle per divide-by-2 period", hi, 20);
    endtask

    task automatic t_fb(input logic [11:0] fc);
        int n;
        restart(1'b0, 12'd0, fc);
        fb_period(n);
        check(n == int'(fc) + 2, "R2 feedback tick period", n, int'(fc) + 2);
        @(negedge clk_osc);
        check(!fb_tick, "R4 feedback tick one cycle wide", fb_tick, 0);
    endtask

    task automatic t_unity;
        int hi = 0;
        restart(1'b0, 12'd3, 12'hFFF);
        repeat (30) @(negedge clk_osc);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk_osc);
            if (fb_tick) hi++;
        end
        check(hi == 8, "R3 all-ones code ticks every cycle", hi, 8);
    endtask

    task automatic t_static;
        int n;
        restart(1'b0, 12'd5, 12'd6);
        repeat (10) @(negedge clk_ref);
        ref_code = 12'd0;
        pre_sel = 1'b1;
        fb_code = 12'd20;
        ref_period(n);
        check(n == 7, "R5 ref period ignores late config change", n, 7);
        fb_period(n);
        check(n == 8, "R5 fb period ignores late config change", n, 8);
    endtask

    task automatic t_hold;
        int seen_bad = 0;
        int ref_before;
        int wait_n = 0;
        int act = 0;
        restart(1'b0, 12'd0, 12'd10);
        repeat (60) @(negedge clk_osc);
        hold_n = 1'b0;
        repeat (4) @(negedge clk_osc);
        ref_before = ref_count;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_osc);
            if (up || dn || fb_tick) seen_bad++;
        end
        check(seen_bad == 0, "R6 no requests or fb ticks while held", seen_bad, 0);
        check(ref_count > ref_before, "R6 ref tick keeps running while held",
              ref_count - ref_before, 1);
        hold_n = 1'b1;
        while (!fb_tick && wait_n < 200) begin @(negedge clk_osc); wait_n++; end
        check(wait_n >= 12 && wait_n <= 32, "R7 first fb tick after release", wait_n, 12);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk_osc);
            if (up || dn) act++;
        end
        check(act > 0, "R7 correction requests resume", act, 1);
    endtask

    task automatic t_pfd_up;
        restart(1'b0, 12'd0, 12'd4094);
        repeat (200) @(negedge clk_osc);
        check(up && !dn, "R8 fast reference holds up", {30'd0, up, dn}, 2);
    endtask

    task automatic t_pfd_dn;
        restart(1'b1, 12'd4095, 12'hFFF);
        repeat (200) @(negedge clk_osc);
        check(!up && dn, "R8 fast feedback holds dn", {30'd0, up, dn}, 1);
    endtask

    task automatic t_pfd_both;
        int viol = 0;
        int ups = 0;
        int dns = 0;
        logic both_prev = 1'b0;
        restart(1'b0, 12'd0, 12'd1);
        repeat (30) @(negedge clk_osc);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk_osc);
            if (both_prev && (up || dn)) viol++;
            if (up) ups++;
            if (dn) dns++;
            both_prev = up && dn;
        end
        check(viol == 0, "R8 both requests clear together", viol, 0);
        check(ups > 0 && dns > 0, "R8 both requests occur", ups * dns, 1);
    endtask

    initial begin
        #3000000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ref(1'b0, 12'd0);
        t_ref(1'b0, 12'd5);
        t_ref(1'b1, 12'd1);
        t_ref(1'b1, 12'd30);
        t_ref_width();
        t_fb(12'd0);
        t_fb(12'd10);
        t_fb(12'd4094);
        t_unity();
        t_static();
        t_hold();
        t_pfd_up();
        t_pfd_dn();
        t_pfd_both();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule